// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register Bank

This block is the storage for a floating-point unit: 32 registers of 64 bits, one combinational read port and one write port. A static mode input picks how doubles are held. In flat mode each register holds a whole 64-bit double. In paired mode a double lives in an even/odd pair, one 32-bit half in the low word of each register.

The write port takes an operation code. The code picks a raw 64-bit store, a low-word store that keeps the upper half, a low-word store that clears the upper half, an upper-word store, or a double store that follows the mode. The double store is the path for both double results and 64-bit integer results of convert-to-long steps. The read port returns the low word, the high word, the double view (which follows the mode) or the raw 64-bit content. A double access to an odd register in paired mode is refused and flagged.

Top module: `fprf_bank`

## Requirements
- R1: A low `rst_n` at a rising clock edge clears every register to zero (synchronous, active low).
- R2: Write op 1 (raw) stores all 64 bits of `wr_data` into register `wr_idx`, in either mode and for any index. Read select 3 (raw) returns the full 64-bit content of `rd_idx`.
- R3: Write op 2 (low keep) stores `wr_data[31:0]` in bits 31:0 and leaves bits 63:32 unchanged.
- R4: Write op 3 (low clear) stores `wr_data[31:0]` in bits 31:0 and clears bits 63:32 to zero.
- R5: Write op 4 (high) stores `wr_data[31:0]` in bits 63:32 and leaves bits 31:0 unchanged.
- R6: Write op 5 (double) with `mode_flat`=1 stores all 64 bits of `wr_data` into any register, odd or even.
- R7: Write op 5 with `mode_flat`=0 and an even index n stores `wr_data[31:0]` in bits 31:0 of n and `wr_data[63:32]` in bits 31:0 of n+1. Bits 63:32 of both registers stay unchanged.
- R8: Write op 5 with `mode_flat`=0 and an odd index sets `wr_illegal` in the same cycle and changes no register. In every other case `wr_illegal` is 0.
- R9: Read select 0 returns {32'b0, bits 31:0} and select 1 returns {32'b0, bits 63:32}. Reads are combinational, so a write shows on the read port after its clock edge.
- R10: Read select 2 (double) returns the full register in flat mode. In paired mode with an even n it returns {bits 31:0 of n+1, bits 31:0 of n}.
- R11: Read select 2 in paired mode with an odd index drives `rd_illegal`=1 and `rd_data`=0. In every other case `rd_illegal` is 0.
- R12: Write ops 0, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_flat | input | 1 | 1: flat 64-bit doubles, 0: paired 32-bit halves (static) |
| wr_op | input | 3 | Write operation code (0 none, 1 raw, 2 low keep, 3 low clear, 4 high, 5 double) |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data (word ops use bits 31:0) |
| wr_illegal | output | 1 | Double write to an odd register in paired mode |
| rd_idx | input | 5 | Read register index |
| rd_sel | input | 2 | Read view (0 low, 1 high, 2 double, 3 raw) |
| rd_data | output | 64 | Read data |
| rd_illegal | output | 1 | Double read of an odd register in paired mode |

## Verification
The bench first loads distinct 64-bit patterns into registers whose halves differ. Each word operation is then followed by a raw read, so keeping the upper half, clearing it and replacing it can be told apart. Paired double writes go to registers already holding a value in their upper halves. This shows whether the split lands in the low words only and in the right order, and the last pair (30/31) covers the top boundary. Odd-index double writes and reads are tried in both modes, which separates the illegal case from the legal odd access in flat mode. A sweep of all 32 registers with index-coded data catches decode and aliasing errors.

// File: rtl/fprf_pkg.sv
// Package: shared encodings for the dual-mode floating-point register bank.
// Assumes: write codes not listed here act as no-ops.
package fprf_pkg;

    // Write operation codes seen on wr_op
    typedef enum logic [2:0] {
        WOP_NONE    = 3'd0,
        WOP_RAW     = 3'd1,
        WOP_LO_KEEP = 3'd2,
        WOP_LO_CLR  = 3'd3,
        WOP_HI      = 3'd4,
        WOP_DBL     = 3'd5
    } wr_op_e;

    // Read views selected by rd_sel
    typedef enum logic [1:0] {
        RSEL_LO  = 2'd0,
        RSEL_HI  = 2'd1,
        RSEL_DBL = 2'd2,
        RSEL_RAW = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/fprf_wr_decode.sv
// Module: turns one write request into per-register half-word write enables and values.
// Assumes: NREG is even and at least 4; word writes take data from the low word of wr_data.
module fprf_wr_decode #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int DW   = 2 * WORD
) (
    input  logic                 mode_flat,
    input  logic [2:0]           wr_op,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [DW-1:0]        wr_data,
    output logic [NREG-1:0]      lo_we,
    output logic [NREG-1:0]      hi_we,
    output logic [NREG-1:0][WORD-1:0] lo_val,
    output logic [NREG-1:0][WORD-1:0] hi_val,
    output logic                 wr_illegal
);
    import fprf_pkg::*;

    logic op_raw, op_lo_keep, op_lo_clr, op_hi, op_dbl;
    logic dbl_flat, dbl_pair;
    logic [WORD-1:0] d_lo, d_hi;

    // Classify the operation and the mode-dependent double path
    always_comb begin
        op_raw     = (wr_op == WOP_RAW);
        op_lo_keep = (wr_op == WOP_LO_KEEP);
        op_lo_clr  = (wr_op == WOP_LO_CLR);
        op_hi      = (wr_op == WOP_HI);
        op_dbl     = (wr_op == WOP_DBL);
        dbl_flat   = op_dbl && mode_flat;
        dbl_pair   = op_dbl && !mode_flat && !wr_idx[0];
        wr_illegal = op_dbl && !mode_flat && wr_idx[0];
        d_lo       = wr_data[WORD-1:0];
        d_hi       = wr_data[DW-1:WORD];
    end

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            localparam bit IS_ODD = (i % 2) == 1;
            logic hit, pair_hit;
            // Per-register enables and values for both halves
            always_comb begin
                hit      = (wr_idx == IDXW'(i));
                pair_hit = dbl_pair && (wr_idx[IDXW-1:1] == (IDXW-1)'(i / 2));
                lo_we[i] = (hit && (op_raw || op_lo_keep || op_lo_clr || dbl_flat)) || pair_hit;
                hi_we[i] = hit && (op_raw || op_lo_clr || op_hi || dbl_flat);
                lo_val[i] = (pair_hit && IS_ODD) ? d_hi : d_lo;
                if (op_lo_clr)
                    hi_val[i] = '0;
                else if (op_hi)
                    hi_val[i] = d_lo;
                else
                    hi_val[i] = d_hi;
            end
        end
    endgenerate

endmodule

// File: rtl/fprf_store.sv
// Module: the register storage, each 64-bit register kept as two independently written halves.
// Assumes: enables come from the write decoder; reset wins over any write.
module fprf_store #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int DW = 2 * WORD
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0]           lo_we,
    input  logic [NREG-1:0]           hi_we,
    input  logic [NREG-1:0][WORD-1:0] lo_val,
    input  logic [NREG-1:0][WORD-1:0] hi_val,
    output logic [NREG-1:0][DW-1:0]   regs_q
);
    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            // Low half: synchronous clear, else load when enabled
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i][WORD-1:0] <= '0;
                else if (lo_we[i])
                    regs_q[i][WORD-1:0] <= lo_val[i];
            end
            // High half: synchronous clear, else load when enabled
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i][DW-1:WORD] <= '0;
                else if (hi_we[i])
                    regs_q[i][DW-1:WORD] <= hi_val[i];
            end
        end
    endgenerate

endmodule

// File: rtl/fprf_rd_mux.sv
// Module: combinational read view selection, including the paired double assembly.
// Assumes: NREG is even, so the odd mate of an even index always exists.
module fprf_rd_mux #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int DW   = 2 * WORD
) (
    input  logic                    mode_flat,
    input  logic [IDXW-1:0]         rd_idx,
    input  logic [1:0]              rd_sel,
    input  logic [NREG-1:0][DW-1:0] regs_q,
    output logic [DW-1:0]           rd_data,
    output logic                    rd_illegal
);
    import fprf_pkg::*;

    logic [DW-1:0] own, mate;

    // Pick the addressed register, its pair mate, and the requested view
    always_comb begin
        own        = regs_q[rd_idx];
        mate       = regs_q[rd_idx | IDXW'(1)];
        rd_illegal = 1'b0;
        case (rd_sel)
            RSEL_LO:  rd_data = {{WORD{1'b0}}, own[WORD-1:0]};
            RSEL_HI:  rd_data = {{WORD{1'b0}}, own[DW-1:WORD]};
            RSEL_DBL: begin
                if (mode_flat)
                    rd_data = own;
                else if (rd_idx[0]) begin
                    rd_data    = '0;
                    rd_illegal = 1'b1;
                end else
                    rd_data = {mate[WORD-1:0], own[WORD-1:0]};
            end
            default:  rd_data = own;
        endcase
    end

endmodule

// File: rtl/fprf_bank.sv
// Module: dual-mode floating-point register bank top; one combinational read port and one write port.
// Assumes: mode_flat is held static between resets; writes land on the rising edge.
module fprf_bank #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int DW   = 2 * WORD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_flat,
    input  logic [2:0]      wr_op,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    output logic            wr_illegal,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [1:0]      rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic            rd_illegal
);
    logic [NREG-1:0]           lo_we, hi_we;
    logic [NREG-1:0][WORD-1:0] lo_val, hi_val;
    logic [NREG-1:0][DW-1:0]   regs_q;

    fprf_wr_decode #(.NREG(NREG), .WORD(WORD)) u_dec (
        .mode_flat  (mode_flat),
        .wr_op      (wr_op),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .lo_we      (lo_we),
        .hi_we      (hi_we),
        .lo_val     (lo_val),
        .hi_val     (hi_val),
        .wr_illegal (wr_illegal)
    );

    fprf_store #(.NREG(NREG), .WORD(WORD)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_we  (lo_we),
        .hi_we  (hi_we),
        .lo_val (lo_val),
        .hi_val (hi_val),
        .regs_q (regs_q)
    );

    fprf_rd_mux #(.NREG(NREG), .WORD(WORD)) u_rd (
        .mode_flat  (mode_flat),
        .rd_idx     (rd_idx),
        .rd_sel     (rd_sel),
        .regs_q     (regs_q),
        .rd_data    (rd_data),
        .rd_illegal (rd_illegal)
    );

endmodule

// File: rtl/fprf_bank_chk.sv
// Module: property checker for fprf_bank, attached by bind; observes ports and the storage.
// Assumes: default parameters match the bound instance.
module fprf_bank_chk #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int DW   = 2 * WORD
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mode_flat,
    input logic [2:0]              wr_op,
    input logic [IDXW-1:0]         wr_idx,
    input logic [DW-1:0]           wr_data,
    input logic                    wr_illegal,
    input logic [IDXW-1:0]         rd_idx,
    input logic [1:0]              rd_sel,
    input logic [DW-1:0]           rd_data,
    input logic                    rd_illegal,
    input logic [NREG-1:0][DW-1:0] regs_q
);
    import fprf_pkg::*;

    // R1: the cycle after reset every register reads as zero
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_q == '0));

    // R4: low-clear write leaves zero on top and the data word below
    assert_lo_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WOP_LO_CLR) |=>
        (regs_q[$past(wr_idx)] == {{WORD{1'b0}}, $past(wr_data[WORD-1:0])}));

    // R5: high write keeps the low half
    assert_hi_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WOP_HI) |=>
        (regs_q[$past(wr_idx)][WORD-1:0] == $past(regs_q[wr_idx][WORD-1:0])));

    // R8: a refused double write changes nothing
    assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(regs_q));

    // R11: a refused double read returns zero
    assert_illegal_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    // R10: paired double read assembles the two low words
    assert_pair_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_flat && rd_sel == RSEL_DBL && !rd_idx[0]) |->
        (rd_data == {regs_q[rd_idx | IDXW'(1)][WORD-1:0], regs_q[rd_idx][WORD-1:0]}));

    // R12: unused operation codes change nothing
    assert_noop_codes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == WOP_NONE || wr_op > WOP_DBL) |=> $stable(regs_q));

endmodule

bind fprf_bank fprf_bank_chk #(.NREG(NREG), .WORD(WORD)) u_chk (.*);

// File: tb/test_fprf_bank.sv
// Bench: scoreboard for fprf_bank; the driver pushes expected items, the monitor pops and compares.
module test_fprf_bank;
    import fprf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_flat = 1'b1;
    logic [2:0]  wr_op = 3'd0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic [4:0]  rd_idx = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        rd_illegal;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        bit          is_wr;
        logic [63:0] data;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event ev_sample;
    logic [63:0] model [32];

    always #2 clk = ~clk;

    fprf_bank i_fprf_bank (
        .clk(clk), .rst_n(rst_n), .mode_flat(mode_flat),
        .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data), .rd_illegal(rd_illegal)
    );

    // Monitor: pop one expected item per sample event and compare
    initial begin
        forever begin
            exp_t e;
            @(ev_sample);
            e = exp_q.pop_front();
            n_checks++;
            if (e.is_wr) begin
                if (wr_illegal !== e.ill) begin
                    n_errors++;
                    $display("FAIL %s: wr_illegal got %b exp %b", e.tag, wr_illegal, e.ill);
                end
            end else if (rd_data !== e.data || rd_illegal !== e.ill) begin
                n_errors++;
                $display("FAIL %s: rd_data/ill got %h/%b exp %h/%b",
                         e.tag, rd_data, rd_illegal, e.data, e.ill);
            end
        end
    end

    // Reference model update, straight from the requirements
    task automatic m_apply(input logic [2:0] op, input logic [4:0] idx, input logic [63:0] d);
        case (op)
            3'd1: model[idx] = d;
            3'd2: model[idx][31:0] = d[31:0];
            3'd3: model[idx] = {32'h0, d[31:0]};
            3'd4: model[idx][63:32] = d[31:0];
            3'd5: begin
                if (mode_flat) model[idx] = d;
                else if (!idx[0]) begin
                    model[idx][31:0]   = d[31:0];
                    model[idx+1][31:0] = d[63:32];
                end
            end
            default: ;
        endcase
    endtask

    task automatic do_reset(input logic flat);
        @(negedge clk);
        rst_n = 1'b0;
        mode_flat = flat;
        wr_op = 3'd0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) model[k] = '0;
    endtask

    task automatic do_wr(input logic [2:0] op, input logic [4:0] idx,
                         input logic [63:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        wr_op = op; wr_idx = idx; wr_data = d;
        e.is_wr = 1'b1; e.data = '0; e.tag = tag;
        e.ill = (op == 3'd5) && !mode_flat && idx[0];
        exp_q.push_back(e);
        #1 -> ev_sample;
        @(posedge clk);
        m_apply(op, idx, d);
        #1 wr_op = 3'd0;
    endtask

    task automatic do_rd(input logic [4:0] idx, input logic [1:0] sel, input string tag);
        exp_t e;
        @(negedge clk);
        rd_idx = idx; rd_sel = sel;
        e.is_wr = 1'b0; e.tag = tag; e.ill = 1'b0;
        case (sel)
            2'd0: e.data = {32'h0, model[idx][31:0]};
            2'd1: e.data = {32'h0, model[idx][63:32]};
            2'd2: begin
                if (mode_flat) e.data = model[idx];
                else if (idx[0]) begin e.data = '0; e.ill = 1'b1; end
                else e.data = {model[idx+1][31:0], model[idx][31:0]};
            end
            default: e.data = model[idx];
        endcase
        exp_q.push_back(e);
        #1 -> ev_sample;
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        #(200000 * 4);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Stimulus
    initial begin
        do_reset(1'b1);
        do_rd(5'd0, 2'd3, "R1");
        do_rd(5'd31, 2'd3, "R1");
        do_wr(3'd1, 5'd3, 64'h0123_4567_89AB_CDEF, "R2 wr");
        do_rd(5'd3, 2'd3, "R2");
        do_rd(5'd3, 2'd0, "R9 lo");
        do_rd(5'd3, 2'd1, "R9 hi");
        do_wr(3'd2, 5'd3, 64'h5555_5555_DEAD_BEEF, "R3 wr");
        do_rd(5'd3, 2'd3, "R3");
        do_wr(3'd3, 5'd3, 64'hAAAA_AAAA_1357_9BDF, "R4 wr");
        do_rd(5'd3, 2'd3, "R4");
        do_wr(3'd4, 5'd3, 64'h7777_7777_CAFE_F00D, "R5 wr");
        do_rd(5'd3, 2'd3, "R5");
        do_wr(3'd5, 5'd7, 64'hFEDC_BA98_7654_3210, "R8 flat odd ok");
        do_rd(5'd7, 2'd2, "R6 R10 flat");
        do_rd(5'd7, 2'd3, "R6 raw");
        do_rd(5'd8, 2'd3, "R6 neighbour");
        do_wr(3'd6, 5'd7, 64'h1111_1111_1111_1111, "R12 wr6");
        do_wr(3'd7, 5'd7, 64'h2222_2222_2222_2222, "R12 wr7");
        do_wr(3'd0, 5'd7, 64'h3333_3333_3333_3333, "R12 wr0");
        do_rd(5'd7, 2'd3, "R12");
        do_reset(1'b1);
        do_rd(5'd7, 2'd3, "R1 after writes");
        do_rd(5'd3, 2'd3, "R1 after writes");

        do_reset(1'b0);
        do_wr(3'd1, 5'd4, 64'hA4A4_A4A4_0404_0404, "R2 paired");
        do_wr(3'd1, 5'd5, 64'hB5B5_B5B5_0505_0505, "R2 paired");
        do_wr(3'd5, 5'd4, 64'h9999_8888_6666_5555, "R7 wr");
        do_rd(5'd4, 2'd3, "R7 even raw");
        do_rd(5'd5, 2'd3, "R7 odd raw");
        do_rd(5'd4, 2'd2, "R10 paired");
        do_wr(3'd5, 5'd5, 64'hDEAD_DEAD_BEEF_BEEF, "R8 odd");
        do_rd(5'd5, 2'd3, "R8 r5 unchanged");
        do_rd(5'd6, 2'd3, "R8 r6 unchanged");
        do_rd(5'd4, 2'd3, "R8 r4 unchanged");
        do_rd(5'd5, 2'd2, "R11");
        do_wr(3'd4, 5'd31, 64'h0000_0000_3131_3131, "R5 r31");
        do_wr(3'd5, 5'd30, 64'h3030_0000_0000_3030, "R7 top pair");
        do_rd(5'd30, 2'd2, "R10 top pair");
        do_rd(5'd31, 2'd3, "R7 r31 high kept");
        do_wr(3'd3, 5'd30, 64'hFFFF_FFFF_0BAD_CAFE, "R4 paired");
        do_rd(5'd30, 2'd3, "R4 paired");

        for (int k = 0; k < 32; k++)
            do_wr(3'd1, 5'(k), {8'(k), 24'h5A5A5A, 8'(~k), 24'hC3C3C3}, "R2 sweep wr");
        for (int k = 0; k < 32; k++)
            do_rd(5'(k), 2'd3, "R2 sweep");
        for (int k = 0; k < 32; k += 2)
            do_rd(5'(k), 2'd2, "R10 sweep");

        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule